// File: doc/BRIEF.md
# In-Place Streaming Stride Reorder

This block reorders a continuous stream of words, one word per clock, in groups of `S2 = 2**LOG` consecutive words. Every group leaves the block in a fixed permuted order. Output word `k` of a group is input word `rotl(k, ROT)` of the group before it, where `rotl` rotates the `LOG`-bit index left by `ROT` positions. Each choice of `ROT` gives a different stride permutation.

The only storage is one single-port memory of exactly `S2` words. Each accepted word is written to a location in the same cycle that the old word at that location is read out. One address serves both the read and the write.

No second buffer is needed because the address pattern changes from one group to the next. Group `i` uses address `rotl(k, i*ROT mod LOG)` for its word `k`. The patterns therefore repeat after at most `LOG` groups, and a small rotate circuit computes them with no table.

The output follows the input by one group plus one register stage. The block raises no valid output until a first full group has been written. Idle cycles (input valid low) hold the stream position and produce no output.

Top module: `stream_perm_inplace`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `out_first` are low.
- R2: The first `S2` accepted words after reset produce no valid output.
- R3: Once `S2` words have been accepted, every accepted word makes `out_valid` high in the following cycle.
- R4: Output word `k` (0-based, counted in accepted-word order within its group) of group `n >= 1` equals input word `((k << ROT) | (k >> (LOG-ROT))) mod S2` of group `n-1`.
- R5: A cycle with `in_valid` low is followed by a cycle with `out_valid` low, and it does not shift the stream position or alter any stored word.
- R6: `out_first` is high exactly with the output word at position 0 of each output group, and never without `out_valid`.
- R7: The memory address used for word `k` of group `i` is `k` rotated left by `(i*ROT) mod LOG` bits. Word 0 therefore always maps to address 0, and word `S2-1` always maps to address `S2-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input word is present this cycle |
| in_data | input | WIDTH | Input word |
| out_valid | output | 1 | `out_data` holds a reordered word |
| out_first | output | 1 | The current output word opens a group |
| out_data | output | WIDTH | Reordered output word |

## Verification
The bench builds two instances with `LOG = 3` (groups of eight), `WIDTH = 16`, and rotation amounts 1 and 2. Both rotations give an address period of three groups, and they step the phase in opposite directions, so a run of nine or more groups wraps the address pattern back to identity several times for each instance. Back-to-back groups exercise the continuous case. A later stretch with regularly spaced idle cycles shows that gaps neither shift word positions nor corrupt words held across a group boundary.

// File: rtl/stream_perm_pkg.sv
package stream_perm_pkg;
  localparam int MAX_BITS = 16;

  // Rotate the low n bits of v left by amt; bits at or above n are zero.
  function automatic logic [MAX_BITS-1:0] rotl_bits(input logic [MAX_BITS-1:0] v,
                                                    input int n, input int amt);
    logic [MAX_BITS-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < n) r[(i + amt) % n] = v[i];
    end
    return r;
  endfunction

  // Advance a rotation phase by step, modulo n.
  function automatic int next_phase(input int ph, input int step, input int n);
    int s;
    s = ph + step;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/perm_addr_gen.sv
module perm_addr_gen #(
  parameter int LOG = 3,
  parameter int ROT = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  output logic [LOG-1:0] word_idx,
  output logic [LOG-1:0] addr,
  output logic           primed
);
  import stream_perm_pkg::*;

  localparam int PW   = $clog2(LOG) + 1;
  localparam int RSTP = ROT % LOG;

  logic [PW-1:0] phase;
  logic          last_word;

  assign last_word = (word_idx == {LOG{1'b1}});
  assign addr      = LOG'(rotl_bits(MAX_BITS'(word_idx), LOG, int'(phase)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_idx <= '0;
      phase    <= '0;
      primed   <= 1'b0;
    end else if (step) begin
      word_idx <= word_idx + 1'b1;
      if (last_word) begin
        phase  <= PW'(next_phase(int'(phase), RSTP, LOG));
        primed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/perm_spram.sv
module perm_spram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // One port: old contents leave while new contents arrive at the same address.
  always_ff @(posedge clk) begin
    if (en) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/stream_perm_inplace.sv
module stream_perm_inplace #(
  parameter int WIDTH = 16,
  parameter int LOG   = 3,
  parameter int ROT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic             out_first,
  output logic [WIDTH-1:0] out_data
);
  localparam int S2 = 1 << LOG;

  logic [LOG-1:0] word_idx;
  logic [LOG-1:0] mem_addr;
  logic           primed;
  logic           emit;

  assign emit = in_valid && primed;

  perm_addr_gen #(.LOG(LOG), .ROT(ROT)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (in_valid),
    .word_idx (word_idx),
    .addr     (mem_addr),
    .primed   (primed)
  );

  perm_spram #(.WIDTH(WIDTH), .DEPTH(S2)) u_mem (
    .clk   (clk),
    .en    (in_valid),
    .addr  (mem_addr),
    .wdata (in_data),
    .rdata (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= emit;
      out_first <= emit && (word_idx == '0);
    end
  end
endmodule

// File: rtl/stream_perm_chk.sv
module stream_perm_chk #(
  parameter int LOG = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           out_valid,
  input logic           out_first,
  input logic           primed,
  input logic [LOG-1:0] word_idx,
  input logic [LOG-1:0] mem_addr
);
  a_r2_silent_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !out_valid);

  a_r3_accept_gives_output: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && primed) |=> out_valid);

  a_r3_primed_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

  a_r5_idle_gives_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r5_idle_holds_position: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(word_idx));

  a_r6_first_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  a_r7_word0_at_addr0: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx == '0) |-> (mem_addr == '0));

  a_r7_last_word_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx == {LOG{1'b1}}) |-> (mem_addr == {LOG{1'b1}}));
endmodule

bind stream_perm_inplace stream_perm_chk #(.LOG(LOG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_first (out_first),
  .primed    (primed),
  .word_idx  (word_idx),
  .mem_addr  (mem_addr)
);

// File: tb/stream_perm_inplace_tb.sv
`timescale 1ns/1ps
module stream_perm_inplace_tb;
  localparam int W  = 16;
  localparam int LG = 3;
  localparam int S2 = 1 << LG;
  localparam int MAXW = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          ov1, of1, ov2, of2;
  logic [W-1:0]  od1, od2;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] hist [MAXW];
  int  n_acc = 0;
  int  last_n = 0;
  bit  last_v = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  stream_perm_inplace #(.WIDTH(W), .LOG(LG), .ROT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov1), .out_first(of1), .out_data(od1));

  stream_perm_inplace #(.WIDTH(W), .LOG(LG), .ROT(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov2), .out_first(of2), .out_data(od2));

  // Source index within the previous group, stated as shifts.
  function automatic int src_of(input int k, input int rot);
    return ((k << rot) | (k >> (LG - rot))) & (S2 - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare both instances against the model for the word accepted last cycle.
  task automatic compare_outputs();
    bit ev;
    int k, g;
    ev = last_v && (last_n >= S2);
    k  = last_n % S2;
    g  = last_n / S2;
    if (last_n < S2) chk("R2 no output while filling", {31'd0, ov1}, {31'd0, ev});
    else if (!last_v) chk("R5 idle cycle output", {31'd0, ov1}, 32'd0);
    else chk("R3 output valid", {31'd0, ov1}, {31'd0, ev});
    chk("R3 output valid rot2", {31'd0, ov2}, {31'd0, ev});
    chk("R6 first flag", {31'd0, of1}, {31'd0, ev && k == 0});
    chk("R6 first flag rot2", {31'd0, of2}, {31'd0, ev && k == 0});
    if (ev) begin
      chk("R4,R7 data rot1", {16'd0, od1}, {16'd0, hist[(g-1)*S2 + src_of(k, 1)]});
      chk("R4,R7 data rot2", {16'd0, od2}, {16'd0, hist[(g-1)*S2 + src_of(k, 2)]});
    end
  endtask

  task automatic cycle(input bit v, input logic [W-1:0] d);
    @(negedge clk);
    compare_outputs();
    in_valid = v;
    in_data  = d;
    last_v   = v;
    if (v) begin
      hist[n_acc] = d;
      last_n = n_acc;
      n_acc++;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R1 valid in reset", {31'd0, ov1}, 32'd0);
      chk("R1 first in reset", {31'd0, of2}, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, ov1 | ov2}, 32'd0);
    chk("R1 first after reset", {31'd0, of1 | of2}, 32'd0);
    // Back-to-back groups: 10 groups wrap the three-group address period.
    for (int i = 0; i < 10 * S2; i++) cycle(1'b1, W'(i * 37 + 5));
    // Gapped stretch: every third cycle idle, 8 more groups.
    for (int i = 0; n_acc < 18 * S2; i++) begin
      if (i % 3 == 2) cycle(1'b0, W'(16'hdead));
      else cycle(1'b1, W'($urandom));
    end
    // Long idle run then resume, words across the gap must survive (R5).
    for (int i = 0; i < 5; i++) cycle(1'b0, W'(16'hbeef));
    for (int i = 0; i < 3 * S2; i++) cycle(1'b1, W'(16'h8000 + i));
    cycle(1'b0, '0);
    cycle(1'b0, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule